// File: doc/BRIEF.md
# Sync-Locked Phase-Programmable Reference Divider

This block runs entirely in a fast free-running clock domain of nominally 336 MHz. It divides that clock by 32 to make a square-wave reference of about 10.5 MHz. Every falling edge of an asynchronous horizontal sync input re-phases the divider. A downstream frequency-multiplying PLL can lock onto the reference and generate a pixel sampling clock that tracks the incoming video line.

The phase of the reference relative to the sync edge can be programmed in 32 positions. A 4-bit start value sets where the divider restarts, in 16 fast-clock steps. A 1-bit invert swaps the half-cycles. When only 16 positions are needed, the invert is left at zero. The block also outputs a copy of the synchronized sync delayed by the selected start value. Downstream logic can then sample sync without jitter at awkward phase settings. The start value and the invert are captured only at a sync falling edge, so a change in the middle of a line cannot shorten a reference pulse.

Top module: `hsync_phase_div`

## Requirements
- R1: The sync input passes through two flops before edge detection. A falling edge is seen when the older stage is high and the newer stage is low. If the sync goes low before clock edge P0, the divider holds the start value just after edge P1, the next edge.
- R2: Between falling edges, the 5-bit divider count advances by one on every fast clock and wraps from 31 to 0.
- R3: On a detected falling edge, the count reloads to the value of `phase_ofs` (0 to 15) instead of zero.
- R4: `ref_clk` equals count bit 4 XORed with the captured invert flag. With the invert flag at 0, it is low while the count is 0 to 15 and high while the count is 16 to 31, giving a 50/50 square wave with a period of 32 clocks.
- R5: If `ref_inv` is 1 when the edge is detected, `ref_clk` is the complement of the R4 waveform until the next falling edge.
- R6: `phase_ofs` and `ref_inv` are captured only on the falling-edge pulse. Changing them mid-line has no effect on `ref_clk` or `sync_dly` until the next falling edge.
- R7: A rising edge of the sync input does not reload the divider; the count keeps advancing.
- R8: `sync_dly` is the newer synchronizer stage delayed through a 16-stage shift line, tapped at the captured start value. With start value k, `sync_dly` goes low k clocks after the reload edge P1; with k = 0 it goes low at P1.
- R9: A synchronous active-high reset clears the synchronizer, the divider, the captured controls and the delay line, so `ref_clk` and `sync_dly` are 0 during reset.
- R10: The falling-edge pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running clock (about 336 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| hsync_async | input | 1 | Asynchronous horizontal sync, active low |
| phase_ofs | input | 4 | Divider start value loaded at each sync falling edge |
| ref_inv | input | 1 | Inverts the reference output, captured at the sync edge |
| ref_clk | output | 1 | Divided reference clock |
| sync_dly | output | 1 | Synchronized sync delayed by the captured start value |

## Verification
Assertions check the counting rules on every cycle: the reload to the start value after a pulse, the advance by one otherwise, a reference that holds steady except at a count wrap, controls that stay unchanged between pulses, and a one-clock edge pulse. Only the bench scenarios can show the absolute timing from the asynchronous sync to the reload, the full waveform of the reference for all 32 phase settings, the insensitivity to mid-line control changes and to rising edges, and the position of the delayed-sync falling edge for each start value.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
    localparam int HPD_OFS_W     = 4;
    localparam int HPD_CNT_W     = HPD_OFS_W + 1;
    localparam int HPD_DLY_DEPTH = 1 << HPD_OFS_W;

    typedef struct packed {
        logic [HPD_CNT_W-1:0] cnt;
        logic [HPD_OFS_W-1:0] ofs;
        logic                 inv;
        logic                 refo;
    } div_state_t;
endpackage

// File: rtl/hpd_sync_edge.sv
module hpd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic newer_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign newer_o = sync_q[STAGES-2];
    assign fall_o  = sync_q[STAGES-1] & ~sync_q[STAGES-2];

    // R10: one-cycle pulse
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/hpd_phase_cnt.sv
module hpd_phase_cnt
    import hpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_i,
    input  logic [HPD_OFS_W-1:0] ofs_i,
    input  logic                 inv_i,
    output logic [HPD_OFS_W-1:0] ofs_o,
    output logic                 ref_o
);
    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            st_d.cnt = HPD_CNT_W'(ofs_i);
            st_d.ofs = ofs_i;
            st_d.inv = inv_i;
        end else begin
            st_d.cnt = st_q.cnt + HPD_CNT_W'(1);
        end
        st_d.refo = st_d.cnt[HPD_CNT_W-1] ^ st_d.inv;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ofs_o = st_q.ofs;
    assign ref_o = st_q.refo;

    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> st_q.cnt == HPD_CNT_W'($past(ofs_i)));
    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !fall_i |=> st_q.cnt == HPD_CNT_W'($past(st_q.cnt) + HPD_CNT_W'(1)));
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !fall_i |=> ($stable(st_q.inv) && $stable(st_q.ofs)));
    assert_ref_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (!fall_i && st_q.cnt[HPD_OFS_W-1:0] != {HPD_OFS_W{1'b1}}) |=> $stable(ref_o));
endmodule

// File: rtl/hpd_sync_delay.sv
module hpd_sync_delay
    import hpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync_i,
    input  logic [HPD_OFS_W-1:0] tap_i,
    output logic                 sync_o
);
    logic [HPD_DLY_DEPTH-1:0] line_d, line_q;

    always_comb begin
        line_d = {line_q[HPD_DLY_DEPTH-2:0], sync_i};
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign sync_o = line_q[tap_i];

    // R8: the first stage follows the input one clock later
    assert_line_entry_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> line_q[0] == $past(sync_i));
endmodule

// File: rtl/hsync_phase_div.sv
module hsync_phase_div
    import hpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hsync_async,
    input  logic [HPD_OFS_W-1:0] phase_ofs,
    input  logic                 ref_inv,
    output logic                 ref_clk,
    output logic                 sync_dly
);
    logic                 sync_newer;
    logic                 sync_fall;
    logic [HPD_OFS_W-1:0] ofs_cap;

    hpd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (hsync_async),
        .newer_o (sync_newer),
        .fall_o  (sync_fall)
    );

    hpd_phase_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .fall_i (sync_fall),
        .ofs_i  (phase_ofs),
        .inv_i  (ref_inv),
        .ofs_o  (ofs_cap),
        .ref_o  (ref_clk)
    );

    hpd_sync_delay u_dly (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_newer),
        .tap_i  (ofs_cap),
        .sync_o (sync_dly)
    );
endmodule

// File: tb/hsync_phase_div_test.sv
module hsync_phase_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_async = 1'b1;
    logic [3:0] phase_ofs = 4'd0;
    logic       ref_inv = 1'b0;
    logic       ref_clk, sync_dly;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hsync_phase_div uut (
        .clk(clk), .rst(rst), .hsync_async(hsync_async),
        .phase_ofs(phase_ofs), .ref_inv(ref_inv),
        .ref_clk(ref_clk), .sync_dly(sync_dly)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(ref_clk == 1'b0, "R9 ref_clk in reset", int'(ref_clk), 0);
        chk(sync_dly == 1'b0, "R9 sync_dly in reset", int'(sync_dly), 0);
        rst = 1'b0;

        for (int combo = 0; combo < 32; combo++) begin
            int ofs = combo % 16;
            int inv = combo / 16;
            hsync_async = 1'b1;
            repeat (24) @(negedge clk);
            phase_ofs = 4'(ofs);
            ref_inv = inv[0];
            hsync_async = 1'b0;
            @(posedge clk);  // P0: first stage captures low
            @(posedge clk);  // P1: reload
            for (int n = 0; n < 60; n++) begin
                int expref;
                @(negedge clk);
                expref = (((ofs + n) >> 4) & 1) ^ inv;
                // R1 R3 R4 R5: waveform from reload; R2 wrap; R7 after rise at n=40
                chk(int'(ref_clk) == expref,
                    n >= 41 ? "R7 ref_clk after rising edge" :
                    n >= 6  ? "R6 ref_clk after mid-line control change" :
                    inv != 0 ? "R5 inverted ref_clk" : "R4 ref_clk phase",
                    int'(ref_clk), expref);
                if (n < 40) begin
                    int expd = (n < ofs) ? 1 : 0;
                    chk(int'(sync_dly) == expd,
                        n >= 6 ? "R6 sync_dly tap unchanged" : "R8 sync_dly delay",
                        int'(sync_dly), expd);
                end
                if (n == 5) begin
                    phase_ofs = ~phase_ofs;
                    ref_inv = ~ref_inv;
                end
                if (n == 40) hsync_async = 1'b1;
            end
        end

        // R1 R2: free-running count after a default edge, checked over two wraps
        hsync_async = 1'b1;
        phase_ofs = 4'd0;
        ref_inv = 1'b0;
        repeat (24) @(negedge clk);
        hsync_async = 1'b0;
        @(posedge clk);
        @(posedge clk);
        for (int n = 0; n < 64; n++) begin
            int e;
            @(negedge clk);
            e = (n >> 4) & 1;
            chk(int'(ref_clk) == e, "R2 divide-by-32 wrap", int'(ref_clk), e);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule